// File: doc/BRIEF.md
# Wrapping Hardware Stack Pointer

This block keeps the stack pointer of a small 8-bit processor and generates the memory addresses for every stack access. The stack lives in a fixed 128-byte window at 0100h–017Fh. Only the low seven pointer bits are stored. The upper nine bits of the 16-bit pointer are constant, so running past either end of the window wraps around silently and raises no flag. The pointer always names the next free byte. A push writes at the pointer and then moves it down. A pop moves the pointer up and then reads there.

The processor core places one request per cycle on the request port. Multi-byte frames are then sequenced one byte per cycle: a subroutine call or return, an interrupt entry or its return, and a single-byte push or pop. Each cycle the block drives a memory address, a write or read strobe, and a code naming which register byte travels on the data bus. The core uses that code to steer its register file. The memory array and the register file sit outside this block. Two further requests act on the pointer alone: a stack reset and a direct load of the low pointer byte.

Top module: `stack_ptr_unit`

## Requirements
- R1: While `rstN` is low and after it rises, `sp` reads 017Fh, `busy` is 0, `memWe` and `memRe` are 0 and `byteSel` is 7 (idle).
- R2: Bits 15..7 of `sp` are always 000000010b. Every `memAddr` driven with a strobe lies in 0100h–017Fh.
- R3: A push byte drives `memWe`=1 with `memAddr` equal to the current `sp`, and `sp` is one lower in the next cycle. A single push (`reqOp`=0) writes one byte with `byteSel`=5 (data byte).
- R4: A pop byte drives `memRe`=1 with `memAddr` equal to `sp`+1, and `sp` equals that address in the next cycle. A single pop (`reqOp`=1) reads one byte with `byteSel`=5.
- R5: A push at 0100h leaves `sp` at 017Fh. A pop at 017Fh reads 0100h and leaves `sp` at 0100h.
- R6: A call (`reqOp`=2) pushes two bytes in consecutive cycles with `byteSel` 0 (PC low) and then 1 (PC high).
- R7: A return (`reqOp`=3) pops two bytes with `byteSel` 1 and then 0.
- R8: An interrupt entry (`reqOp`=4) pushes five bytes with `byteSel` 0, 1, 2 (X), 3 (A), 4 (condition codes) in that order. Y has no code and is never saved.
- R9: An interrupt return (`reqOp`=5) pops five bytes with `byteSel` 4, 3, 2, 1, 0.
- R10: A stack reset request (`reqOp`=6) sets `sp` to 017Fh in the next cycle, with no memory access.
- R11: A load request (`reqOp`=7) sets bits 6..0 of `sp` to `loadData[6:0]` in the next cycle. Bit 7 of `loadData` is ignored.
- R12: A request is taken at a rising edge where `reqValid`=1 and `busy`=0. Sequenced bytes start in the following cycle, and `busy` stays 1 for exactly the length of the frame. Requests made while `busy` is 1 are ignored, and `memWe` and `memRe` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Request code (0 push, 1 pop, 2 call, 3 return, 4 interrupt, 5 interrupt return, 6 stack reset, 7 load) |
| loadData | input | 8 | Value for the load request |
| memAddr | output | 16 | Stack memory address |
| memWe | output | 1 | Write strobe for a push byte |
| memRe | output | 1 | Read strobe for a pop byte |
| byteSel | output | 3 | Register byte on the bus (0 PCL, 1 PCH, 2 X, 3 A, 4 CC, 5 data, 7 idle) |
| busy | output | 1 | Frame sequence in progress |
| sp | output | 16 | Current stack pointer |

## Verification
A chain of requests is applied from reset so that every frame kind runs from a known pointer. The per-byte addresses, strobes and byte codes show whether the decrement follows the write and the increment comes before the read, and whether each frame runs in its own order. Pops and pushes placed at the two window edges separate a correct wrap from an off-by-one. A load with bit 7 set shows whether that bit leaks into the pointer. A stack reset issued during an interrupt frame shows whether requests made while busy are ignored, and a reset in mid-sequence shows that the idle state returns.

// File: rtl/stack_pkg.sv
package stack_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_INT  = 3'd4,
    OP_IRET = 3'd5,
    OP_RSP  = 3'd6,
    OP_LOAD = 3'd7
  } stackOp_e;

  typedef enum logic [2:0] {
    SEL_PCL  = 3'd0,
    SEL_PCH  = 3'd1,
    SEL_X    = 3'd2,
    SEL_A    = 3'd3,
    SEL_CC   = 3'd4,
    SEL_DATA = 3'd5,
    SEL_IDLE = 3'd7
  } byteSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic rst;
    logic load;
  } spStrobe_t;

  localparam int SINGLE_FRAME = 1;
  localparam int CALL_FRAME   = 2;
  localparam int INT_FRAME    = 5;
  localparam int STEP_W       = 3;

endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  output spStrobe_t  strobe,
  output logic [2:0] byteSel,
  output logic       busy
);

  logic             active;
  stackOp_e         curOp;
  logic [STEP_W-1:0] stepIdx;
  logic [STEP_W-1:0] lastIdx;
  logic             take;

  function automatic stackOp_e toOp(input logic [2:0] code);
    return stackOp_e'(code);
  endfunction

  function automatic logic [STEP_W-1:0] frameLast(input stackOp_e op);
    case (op)
      OP_CALL, OP_RET:  return STEP_W'(CALL_FRAME - 1);
      OP_INT, OP_IRET:  return STEP_W'(INT_FRAME - 1);
      default:          return STEP_W'(SINGLE_FRAME - 1);
    endcase
  endfunction

  // interrupt entry order; other frames are derived from it
  function automatic byteSel_e intOrder(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    return SEL_PCL;
      3'd1:    return SEL_PCH;
      3'd2:    return SEL_X;
      3'd3:    return SEL_A;
      default: return SEL_CC;
    endcase
  endfunction

  function automatic byteSel_e selFor(input stackOp_e op, input logic [STEP_W-1:0] idx);
    case (op)
      OP_CALL: return intOrder(idx);
      OP_RET:  return intOrder(STEP_W'(CALL_FRAME - 1) - idx);
      OP_INT:  return intOrder(idx);
      OP_IRET: return intOrder(STEP_W'(INT_FRAME - 1) - idx);
      default: return SEL_DATA;
    endcase
  endfunction

  function automatic logic isPushOp(input stackOp_e op);
    return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_INT);
  endfunction

  assign take    = reqValid && !active;
  assign lastIdx = frameLast(curOp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      curOp   <= OP_PUSH;
      stepIdx <= '0;
    end else if (active) begin
      if (stepIdx == lastIdx) begin
        active  <= 1'b0;
        stepIdx <= '0;
      end else begin
        stepIdx <= stepIdx + 1'b1;
      end
    end else if (take && toOp(reqOp) != OP_RSP && toOp(reqOp) != OP_LOAD) begin
      active  <= 1'b1;
      curOp   <= toOp(reqOp);
      stepIdx <= '0;
    end
  end

  always_comb begin
    strobe.push = active && isPushOp(curOp);
    strobe.pop  = active && !isPushOp(curOp);
    strobe.rst  = take && (toOp(reqOp) == OP_RSP);
    strobe.load = take && (toOp(reqOp) == OP_LOAD);
    byteSel     = active ? selFor(curOp, stepIdx) : SEL_IDLE;
  end

  assign busy = active;

endmodule

// File: rtl/stack_dp.sv
module stack_dp
  import stack_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 7,
  parameter int WORD_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStrobe_t         strobe,
  input  logic [WORD_W-1:0] loadData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] sp
);

  localparam int HI_W = ADDR_W - PTR_W;
  localparam logic [HI_W-1:0]  HI_BITS = BASE[ADDR_W-1:PTR_W];
  localparam logic [PTR_W-1:0] TOP     = '1;

  logic [PTR_W-1:0] spLow;
  logic [PTR_W-1:0] spUp;
  logic             unusedHighBits;

  // bits above the live field cannot reach the pointer
  assign unusedHighBits = ^loadData[WORD_W-1:PTR_W];

  assign spUp = spLow + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)            spLow <= TOP;
    else if (strobe.rst)  spLow <= TOP;
    else if (strobe.load) spLow <= loadData[PTR_W-1:0];
    else if (strobe.push) spLow <= spLow - 1'b1;
    else if (strobe.pop)  spLow <= spUp;
  end

  assign sp      = {HI_BITS, spLow};
  assign memAddr = strobe.pop ? {HI_BITS, spUp} : {HI_BITS, spLow};

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stack_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 7,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [WORD_W-1:0] loadData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [2:0]        byteSel,
  output logic              busy,
  output logic [ADDR_W-1:0] sp
);

  spStrobe_t strobe;

  stack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .strobe   (strobe),
    .byteSel  (byteSel),
    .busy     (busy)
  );

  stack_dp #(
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W),
    .WORD_W (WORD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadData (loadData),
    .memAddr  (memAddr),
    .sp       (sp)
  );

  assign memWe = strobe.push;
  assign memRe = strobe.pop;

endmodule

// File: rtl/stack_ptr_checker.sv
module stack_ptr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [2:0]  reqOp,
  input logic [7:0]  loadData,
  input logic [15:0] memAddr,
  input logic        memWe,
  input logic        memRe,
  input logic [2:0]  byteSel,
  input logic        busy,
  input logic [15:0] sp
);

  logic unusedLoadTop;
  assign unusedLoadTop = loadData[7];

  a_r3_push_addr: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr == sp);

  a_r3_push_decrement: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> sp[6:0] == $past(sp[6:0]) - 7'd1);

  a_r4_pop_lands: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> sp == $past(memAddr));

  a_r8_cc_ends_entry: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && byteSel == 3'd4) |=> !busy);

  a_r9_pcl_ends_pop: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && byteSel == 3'd0) |=> !busy);

  a_r10_reset_stack: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqOp == 3'd6) |=> sp == 16'h017F);

  a_r11_load_low: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqOp == 3'd7) |=> sp[6:0] == $past(loadData[6:0]));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (byteSel == 3'd7 && !memWe && !memRe));

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

endmodule

bind stack_ptr_unit stack_ptr_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .loadData (loadData),
  .memAddr  (memAddr),
  .memWe    (memWe),
  .memRe    (memRe),
  .byteSel  (byteSel),
  .busy     (busy),
  .sp       (sp)
);

// File: tb/stack_ptr_unit_bench.sv
`timescale 1ns/1ps
module stack_ptr_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [7:0]  loadData = 8'd0;
  logic [15:0] memAddr;
  logic        memWe;
  logic        memRe;
  logic [2:0]  byteSel;
  logic        busy;
  logic [15:0] sp;

  int nChecks = 0;
  int errors  = 0;
  bit finished = 1'b0;
  logic [6:0] mSp;

  always #2.5 clk = ~clk;

  stack_ptr_unit u_stack_ptr_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .loadData(loadData), .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .byteSel(byteSel), .busy(busy), .sp(sp)
  );

  // scripted chain from reset: op, load value, pointer after completion
  localparam int NV = 13;
  localparam logic [2:0]  V_OP [NV] = '{3'd0, 3'd2, 3'd4, 3'd5, 3'd3, 3'd1, 3'd1,
                                        3'd0, 3'd7, 3'd2, 3'd6, 3'd7, 3'd4};
  localparam logic [7:0]  V_DAT[NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                        8'h00, 8'h85, 8'h00, 8'h00, 8'h01, 8'h00};
  localparam logic [15:0] V_SP [NV] = '{16'h017E, 16'h017C, 16'h0177, 16'h017C, 16'h017E,
                                        16'h017F, 16'h0100, 16'h017F, 16'h0105, 16'h0103,
                                        16'h017F, 16'h0101, 16'h017C};

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int opLen(input logic [2:0] op);
    if (op == 3'd2 || op == 3'd3) return 2;
    if (op == 3'd4 || op == 3'd5) return 5;
    return 1;
  endfunction

  function automatic logic [2:0] expSel(input logic [2:0] op, input int k);
    logic [2:0] entry [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4};
    case (op)
      3'd2: return entry[k];
      3'd3: return entry[1 - k];
      3'd4: return entry[k];
      3'd5: return entry[4 - k];
      default: return 3'd5;
    endcase
  endfunction

  task automatic doOp(input logic [2:0] op, input logic [7:0] d);
    logic [15:0] eAddr;
    bit isPush;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; loadData = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (op == 3'd6) begin
      mSp = 7'h7F;
      check(sp == {9'd2, mSp}, "R10 stack reset", sp, {9'd2, mSp});
      check(!busy && !memWe && !memRe, "R10 no access", {busy, memWe, memRe}, 0);
    end else if (op == 3'd7) begin
      mSp = d[6:0];
      check(sp == {9'd2, mSp}, "R11 load low bits", sp, {9'd2, mSp});
      check(!busy, "R11 no busy", busy, 0);
    end else begin
      isPush = (op == 3'd0 || op == 3'd2 || op == 3'd4);
      for (int k = 0; k < opLen(op); k++) begin
        if (isPush) begin
          eAddr = {9'd2, mSp};
          mSp = mSp - 7'd1;
        end else begin
          mSp = mSp + 7'd1;
          eAddr = {9'd2, mSp};
        end
        check(busy, "R12 busy in frame", busy, 1);
        check(memAddr == eAddr, isPush ? "R3 push address" : "R4 pop address", memAddr, eAddr);
        check(memWe == isPush && memRe == !isPush, opTag(op), {memWe, memRe}, {isPush, !isPush});
        check(byteSel == expSel(op, k), opTag(op), byteSel, expSel(op, k));
        @(negedge clk);
      end
      check(!busy, "R12 busy drops", busy, 0);
      check(sp == {9'd2, mSp}, "R2 pointer after frame", sp, {9'd2, mSp});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sp == 16'h017F && !busy, "R1 in reset", sp, 16'h017F);
    rstN = 1'b1;
    @(negedge clk);
    check(sp == 16'h017F, "R1 after reset sp", sp, 16'h017F);
    check(!busy && !memWe && !memRe && byteSel == 3'd7, "R1 idle outputs",
          {busy, memWe, memRe, byteSel}, 32'h7);
    mSp = 7'h7F;

    // table walk; wrap cases at rows 6 and 7 (R5)
    for (int i = 0; i < NV; i++) begin
      doOp(V_OP[i], V_DAT[i]);
      check(sp == V_SP[i], (i == 6 || i == 7) ? "R5 wrap" : "R2 table pointer", sp, V_SP[i]);
    end

    // R12: stack reset issued during an interrupt frame is ignored
    doOp(3'd7, 8'h10);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd4;
    @(negedge clk);
    reqOp = 3'd6;
    check(busy, "R12 busy at frame start", busy, 1);
    repeat (4) @(negedge clk);
    reqValid = 1'b0;
    check(busy && byteSel == 3'd4, "R12 last byte reached", byteSel, 3'd4);
    @(negedge clk);
    check(!busy, "R12 frame ended", busy, 0);
    check(sp == 16'h010B, "R12 ignored request", sp, 16'h010B);
    mSp = 7'h0B;

    // R1: reset in mid-frame returns the idle state
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd2;
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check(sp == 16'h017F && !busy && !memWe, "R1 mid-frame reset", sp, 16'h017F);
    rstN = 1'b1;
    mSp = 7'h7F;
    doOp(3'd1, 8'h00);
    check(sp == 16'h0100, "R5 pop wrap after reset", sp, 16'h0100);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, nChecks);
    $finish;
  end

endmodule